// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block lets a host reach a small file of control registers over a two-wire serial link with a clock line and an open-drain data line. An active-low enable input gates the whole interface. The block watches both lines through synchronizers on its own system clock. It recognises start and stop conditions and checks the 7-bit device address. A write transfer carries a register index and one data byte. A read transfer sets the index, then a repeated start switches the direction and the slave shifts one register byte back to the host.

The register contents feed the window address logic of a field memory. The write window has a start block, a horizontal size, a signed stride, a vertical size and three control flags. The read window has a start block, a horizontal size, an unsigned stride, a vertical size and one enable flag. A fixed identification byte sits at index 00h. Bits above each field's width are never stored, so they always read back as zero.

Top module: `twi_regfile_slave`

## Requirements
- R1: A falling data line while the clock is high is a start. It begins a new address phase from any state and keeps the last index. A rising data line while the clock is high is a stop. It ends the transfer with nothing further written.
- R2: The first byte after a start carries the 7-bit device address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). The slave acknowledges only address 0 by holding the data line low through the ninth clock. For any other address it leaves the line released and ignores the rest of the transfer.
- R3: In a write transfer, the byte after the address is the register index and the byte after that is the data. Each byte is sampled MSB first on the rising clock edges and is acknowledged, and the data is stored at that index.
- R4: After a write-direction address and an index byte, a repeated start with a read-direction address makes the slave drive the indexed byte MSB first over eight clocks. It then releases the line for the host's acknowledge bit and drives nothing more until the next start.
- R5: Index 00h always reads 46h. A write to it is acknowledged but changes nothing.
- R6: Indices 02h to 13h are read/write and reset to 00h. Only some bits are kept: 1Fh at 03h, 07h and 0Ch; 03h at 05h and 0Eh; 0Fh at 10h; E0h at 0Ah; 80h at 13h. All other indices in that range keep the full byte, and dropped bits read as zero.
- R7: Index 01h and indices 14h to FFh read 00h. Writes to them are acknowledged but change nothing.
- R8: While en_n is high the slave releases the data line, acknowledges nothing and writes no register. Raising en_n also abandons any transfer in progress.
- R9: The output fields are built from the registers with the high byte on top:
  - write start = {03h[4:0], 02h}
  - write x size = {05h[1:0], 04h}
  - write stride = {07h[4:0], 06h}
  - write y size = {09h, 08h}
  - 0Ah bits 7, 6 and 5 = write enable, x-mirror and freeze
  - read start = {0Ch[4:0], 0Bh}
  - read x size = {0Eh[1:0], 0Dh}
  - read stride = {10h[3:0], 0Fh}
  - read y size = {12h, 11h}
  - 13h bit 7 = read enable

  A field changes only after a register write.
- R10: The slave changes its data-line drive only after a falling clock edge, a start, a stop or a disable. The line is therefore stable for the whole high phase of every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the bus |
| en_n | input | 1 | Active-low interface enable |
| sda_oe | output | 1 | 1 pulls the data line low |
| wwin_start | output | 13 | Write window start block |
| wwin_xsize | output | 10 | Write window horizontal size |
| wwin_stride | output | 13 | Write window stride, two's complement |
| wwin_ysize | output | 16 | Write window vertical size |
| wwin_enable | output | 1 | Write window mode enable |
| wwin_xmirror | output | 1 | Write horizontal mirror enable |
| wwin_freeze | output | 1 | Write freeze enable |
| rwin_start | output | 13 | Read window start block |
| rwin_xsize | output | 10 | Read window horizontal size |
| rwin_stride | output | 12 | Read window stride |
| rwin_ysize | output | 16 | Read window vertical size |
| rwin_enable | output | 1 | Read window mode enable |

## Verification
On every cycle the assertions check four things. The data-line drive moves only after a clock fall, a bus condition or a disable. A disabled interface neither drives the line nor writes. The output fields stay still unless a write lands, and writes aimed at the identification byte or an unmapped index leave them still as well. Only the bench scenarios can show the protocol-level results: address matching, the acknowledge bits seen on the bus, the bit order and masking of data read back, repeated starts that redirect an access, and a stop that cuts a transfer short.

// File: rtl/twi_rf_pkg.sv
package twi_rf_pkg;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 8;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam int FIRST_RW  = 2;
    localparam int NREG      = 20;

    localparam int START_W   = 13;
    localparam int XSIZE_W   = 10;
    localparam int WSTRD_W   = 13;
    localparam int RSTRD_W   = 12;
    localparam int YSIZE_W   = 16;
    localparam int FIELD_W   = 2 * START_W + 2 * XSIZE_W + WSTRD_W + RSTRD_W
                             + 2 * YSIZE_W + 4;

    // low-byte index of each two-byte field; the high byte sits one above
    localparam int RX_WSTART = 2;
    localparam int RX_WXSIZE = 4;
    localparam int RX_WSTRD  = 6;
    localparam int RX_WYSIZE = 8;
    localparam int RX_WCTRL  = 10;
    localparam int RX_RSTART = 11;
    localparam int RX_RXSIZE = 13;
    localparam int RX_RSTRD  = 15;
    localparam int RX_RYSIZE = 17;
    localparam int RX_RCTRL  = 19;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_ADDR_ACK, PH_INDEX,
        PH_INDEX_ACK, PH_WDATA, PH_WDATA_ACK, PH_SEND
    } phase_e;

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        byte_t             sh;
        idx_t              idx;
        logic              oe;
    } fsm_t;

    // bits a register keeps; zero for anything outside the writable range
    function automatic byte_t keep_mask(input int i);
        if (i < FIRST_RW || i >= NREG)                          return '0;
        if (i == RX_WSTART + 1 || i == RX_WSTRD + 1 || i == RX_RSTART + 1)
                                                                return 8'h1F;
        if (i == RX_WXSIZE + 1 || i == RX_RXSIZE + 1)           return 8'h03;
        if (i == RX_RSTRD + 1)                                  return 8'h0F;
        if (i == RX_WCTRL)                                      return 8'hE0;
        if (i == RX_RCTRL)                                      return 8'h80;
        return 8'hFF;
    endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb chain_d = {chain_q[STAGES-2:0], d[g]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign q[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = scl_s;
        sda_d = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign ev_start = scl_q & scl_s & sda_q & ~sda_s;
    assign ev_stop  = scl_q & scl_s & ~sda_q & sda_s;
    assign ev_rise  = ~scl_q & scl_s;
    assign ev_fall  = scl_q & ~scl_s;
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
    import twi_rf_pkg::*;
#(
    parameter byte_t ID_VALUE = 8'h46
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  idx_t               wr_idx,
    input  byte_t              wr_data,
    input  idx_t               rd_idx,
    output byte_t              rd_data,
    output logic [START_W-1:0] wwin_start,
    output logic [XSIZE_W-1:0] wwin_xsize,
    output logic [WSTRD_W-1:0] wwin_stride,
    output logic [YSIZE_W-1:0] wwin_ysize,
    output logic               wwin_enable,
    output logic               wwin_xmirror,
    output logic               wwin_freeze,
    output logic [START_W-1:0] rwin_start,
    output logic [XSIZE_W-1:0] rwin_xsize,
    output logic [RSTRD_W-1:0] rwin_stride,
    output logic [YSIZE_W-1:0] rwin_ysize,
    output logic               rwin_enable
);
    byte_t regs_d [FIRST_RW:NREG-1];
    byte_t regs_q [FIRST_RW:NREG-1];

    always_comb begin
        for (int i = FIRST_RW; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en && wr_idx == IDX_W'(i))
                regs_d[i] = wr_data & keep_mask(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = FIRST_RW; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = FIRST_RW; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx == '0) rd_data = ID_VALUE;
        for (int i = FIRST_RW; i < NREG; i++)
            if (rd_idx == IDX_W'(i)) rd_data = regs_q[i];
    end

    assign wwin_start   = {regs_q[RX_WSTART+1][START_W-BYTE_W-1:0], regs_q[RX_WSTART]};
    assign wwin_xsize   = {regs_q[RX_WXSIZE+1][XSIZE_W-BYTE_W-1:0], regs_q[RX_WXSIZE]};
    assign wwin_stride  = {regs_q[RX_WSTRD+1][WSTRD_W-BYTE_W-1:0],  regs_q[RX_WSTRD]};
    assign wwin_ysize   = {regs_q[RX_WYSIZE+1], regs_q[RX_WYSIZE]};
    assign wwin_enable  = regs_q[RX_WCTRL][7];
    assign wwin_xmirror = regs_q[RX_WCTRL][6];
    assign wwin_freeze  = regs_q[RX_WCTRL][5];
    assign rwin_start   = {regs_q[RX_RSTART+1][START_W-BYTE_W-1:0], regs_q[RX_RSTART]};
    assign rwin_xsize   = {regs_q[RX_RXSIZE+1][XSIZE_W-BYTE_W-1:0], regs_q[RX_RXSIZE]};
    assign rwin_stride  = {regs_q[RX_RSTRD+1][RSTRD_W-BYTE_W-1:0],  regs_q[RX_RSTRD]};
    assign rwin_ysize   = {regs_q[RX_RYSIZE+1], regs_q[RX_RYSIZE]};
    assign rwin_enable  = regs_q[RX_RCTRL][7];
endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave
    import twi_rf_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR    = 7'h00,
    parameter byte_t      ID_VALUE    = 8'h46,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               en_n,
    output logic               sda_oe,
    output logic [START_W-1:0] wwin_start,
    output logic [XSIZE_W-1:0] wwin_xsize,
    output logic [WSTRD_W-1:0] wwin_stride,
    output logic [YSIZE_W-1:0] wwin_ysize,
    output logic               wwin_enable,
    output logic               wwin_xmirror,
    output logic               wwin_freeze,
    output logic [START_W-1:0] rwin_start,
    output logic [XSIZE_W-1:0] rwin_xsize,
    output logic [RSTRD_W-1:0] rwin_stride,
    output logic [YSIZE_W-1:0] rwin_ysize,
    output logic               rwin_enable
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic  en_n_s, scl_s, sda_s;
    logic  ev_start, ev_stop, ev_rise, ev_fall;
    logic  wr_en;
    idx_t  wr_idx;
    byte_t rd_data;
    fsm_t  st_d, st_q;

    twi_line_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk (clk), .rst_n (rst_n),
        .d   ({en_n, scl_in, sda_in}),
        .q   ({en_n_s, scl_s, sda_s})
    );

    twi_bus_events u_evt (
        .clk (clk), .rst_n (rst_n), .scl_s (scl_s), .sda_s (sda_s),
        .ev_start (ev_start), .ev_stop (ev_stop),
        .ev_rise (ev_rise), .ev_fall (ev_fall)
    );

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (en_n_s) begin
            st_d.ph  = PH_IDLE;
            st_d.oe  = 1'b0;
            st_d.cnt = '0;
        end else if (ev_start) begin
            st_d.ph  = PH_ADDR;
            st_d.oe  = 1'b0;
            st_d.cnt = '0;
        end else if (ev_stop) begin
            st_d.ph  = PH_IDLE;
            st_d.oe  = 1'b0;
        end else begin
            unique case (st_q.ph)
                PH_ADDR, PH_INDEX, PH_WDATA: begin
                    if (ev_rise && st_q.cnt < LAST_BIT) begin
                        st_d.sh  = {st_q.sh[BYTE_W-2:0], sda_s};
                        st_d.cnt = st_q.cnt + 1'b1;
                    end else if (ev_fall && st_q.cnt == LAST_BIT) begin
                        st_d.cnt = '0;
                        st_d.oe  = 1'b1;
                        if (st_q.ph == PH_ADDR) begin
                            if (st_q.sh[BYTE_W-1:1] == SLV_ADDR) st_d.ph = PH_ADDR_ACK;
                            else begin
                                st_d.ph = PH_IDLE;
                                st_d.oe = 1'b0;
                            end
                        end else if (st_q.ph == PH_INDEX) begin
                            st_d.ph  = PH_INDEX_ACK;
                            st_d.idx = st_q.sh;
                        end else begin
                            st_d.ph = PH_WDATA_ACK;
                            wr_en   = 1'b1;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (ev_fall) begin
                        if (st_q.sh[0]) begin
                            st_d.ph = PH_SEND;
                            st_d.sh = rd_data;
                            st_d.oe = ~rd_data[BYTE_W-1];
                        end else begin
                            st_d.ph = PH_INDEX;
                            st_d.oe = 1'b0;
                        end
                    end
                end
                PH_INDEX_ACK: begin
                    if (ev_fall) begin
                        st_d.ph = PH_WDATA;
                        st_d.oe = 1'b0;
                    end
                end
                PH_WDATA_ACK: begin
                    if (ev_fall) begin
                        st_d.ph = PH_IDLE;
                        st_d.oe = 1'b0;
                    end
                end
                PH_SEND: begin
                    if (ev_fall) begin
                        if (st_q.cnt == LAST_BIT - 1'b1) begin
                            st_d.ph  = PH_IDLE;
                            st_d.oe  = 1'b0;
                            st_d.cnt = '0;
                        end else begin
                            st_d.sh  = {st_q.sh[BYTE_W-2:0], 1'b0};
                            st_d.oe  = ~st_q.sh[BYTE_W-2];
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, cnt: '0, sh: '0, idx: '0, oe: 1'b0};
        else        st_q <= st_d;
    end

    assign sda_oe = st_q.oe;
    assign wr_idx = st_q.idx;

    twi_reg_bank #(.ID_VALUE(ID_VALUE)) u_bank (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (st_q.sh),
        .rd_idx (st_q.idx), .rd_data (rd_data),
        .wwin_start (wwin_start), .wwin_xsize (wwin_xsize),
        .wwin_stride (wwin_stride), .wwin_ysize (wwin_ysize),
        .wwin_enable (wwin_enable), .wwin_xmirror (wwin_xmirror),
        .wwin_freeze (wwin_freeze),
        .rwin_start (rwin_start), .rwin_xsize (rwin_xsize),
        .rwin_stride (rwin_stride), .rwin_ysize (rwin_ysize),
        .rwin_enable (rwin_enable)
    );
endmodule

// File: rtl/twi_rf_checker.sv
module twi_rf_checker
    import twi_rf_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               sda_oe,
    input logic               en_n_s,
    input logic               ev_start,
    input logic               ev_stop,
    input logic               ev_fall,
    input logic               wr_en,
    input idx_t               wr_idx,
    input logic [FIELD_W-1:0] fields
);
    AST_SDA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |->
        ($past(ev_fall) || $past(ev_start) || $past(ev_stop) || $past(en_n_s)))
        else $error("sda drive moved outside a clock fall"); // R10

    AST_DISABLED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_s |=> !sda_oe)
        else $error("sda driven while disabled"); // R8

    AST_NO_WRITE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_s |-> !wr_en)
        else $error("register write while disabled"); // R8

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fields))
        else $error("fields moved without a write"); // R9

    AST_ID_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |=> $stable(fields))
        else $error("write to id index changed a field"); // R5

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IDX_W'(1) || wr_idx >= IDX_W'(NREG))) |=> $stable(fields))
        else $error("unmapped write changed a field"); // R7
endmodule

bind twi_regfile_slave twi_rf_checker u_chk (
    .clk (clk), .rst_n (rst_n), .sda_oe (sda_oe), .en_n_s (en_n_s),
    .ev_start (ev_start), .ev_stop (ev_stop), .ev_fall (ev_fall),
    .wr_en (wr_en), .wr_idx (wr_idx),
    .fields ({wwin_start, wwin_xsize, wwin_stride, wwin_ysize,
              wwin_enable, wwin_xmirror, wwin_freeze,
              rwin_start, rwin_xsize, rwin_stride, rwin_ysize, rwin_enable})
);

// File: tb/sim_twi_regfile_slave.sv
module sim_twi_regfile_slave;
    localparam int Q  = 4;
    localparam int FW = 107;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, scl_h = 1'b1, sda_h = 1'b1, en_n = 1'b1;
    logic sda_oe;
    logic [12:0] wst, rst_;
    logic [9:0]  wxs, rxs;
    logic [12:0] wsd;
    logic [11:0] rsd;
    logic [15:0] wys, rys;
    logic        wen, wxm, wfz, ren;
    wire         sda_bus = sda_h & ~sda_oe;

    twi_regfile_slave u0 (
        .clk (clk), .rst_n (rst_n), .scl_in (scl_h), .sda_in (sda_bus),
        .en_n (en_n), .sda_oe (sda_oe),
        .wwin_start (wst), .wwin_xsize (wxs), .wwin_stride (wsd), .wwin_ysize (wys),
        .wwin_enable (wen), .wwin_xmirror (wxm), .wwin_freeze (wfz),
        .rwin_start (rst_), .rwin_xsize (rxs), .rwin_stride (rsd), .rwin_ysize (rys),
        .rwin_enable (ren)
    );

    int n_chk = 0, n_err = 0;
    logic cmp_en = 1'b0;
    logic done = 1'b0;
    logic [7:0] model [256];
    int dis_cnt = 0;

    function automatic logic [7:0] kept(input int i);
        case (i)
            3, 7, 12: return 8'h1F;
            5, 14:    return 8'h03;
            16:       return 8'h0F;
            10:       return 8'hE0;
            19:       return 8'h80;
            default:  return (i >= 2 && i <= 19) ? 8'hFF : 8'h00;
        endcase
    endfunction

    function automatic logic [FW-1:0] model_fields();
        return {model[3][4:0], model[2], model[5][1:0], model[4], model[7][4:0], model[6],
                model[9], model[8], model[10][7], model[10][6], model[10][5],
                model[12][4:0], model[11], model[14][1:0], model[13], model[16][3:0], model[15],
                model[18], model[17], model[19][7]};
    endfunction

    wire [FW-1:0] port_fields = {wst, wxs, wsd, wys, wen, wxm, wfz, rst_, rxs, rsd, rys, ren};

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // every-clock comparison of the field ports against the model
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            n_chk++;
            if (port_fields !== model_fields()) begin
                n_err++;
                $display("FAIL R9 fields act=%h exp=%h", port_fields, model_fields());
            end
        end
        dis_cnt = en_n ? dis_cnt + 1 : 0;
        if (rst_n && dis_cnt > 4) begin
            n_chk++;
            if (sda_oe !== 1'b0) begin
                n_err++;
                $display("FAIL R8 sda_oe while disabled act=%b exp=0", sda_oe);
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic h_start();
        sda_h = 1'b1; scl_h = 1'b1; wt(Q);
        sda_h = 1'b0; wt(Q);
        scl_h = 1'b0; wt(Q);
    endtask

    task automatic h_rstart();
        sda_h = 1'b1; wt(Q);
        scl_h = 1'b1; wt(Q);
        sda_h = 1'b0; wt(Q);
        scl_h = 1'b0; wt(Q);
    endtask

    task automatic h_stop();
        sda_h = 1'b0; wt(Q);
        scl_h = 1'b1; wt(Q);
        sda_h = 1'b1; wt(2 * Q);
    endtask

    task automatic clk_bit(input logic b, output logic s, output logic stab);
        logic a, c;
        sda_h = b; wt(Q);
        scl_h = 1'b1; wt(1);
        a = sda_bus; wt(Q - 1);
        s = sda_bus; wt(Q - 1);
        c = sda_bus; wt(1);
        scl_h = 1'b0; wt(Q);
        stab = (a == s) && (s == c);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s, st;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s, st);
        clk_bit(1'b1, ack, st);
        chk(st, "R10 ack bit stable while clock high", {31'd0, st}, 32'd1);
    endtask

    task automatic recv_byte(output logic [7:0] d);
        logic s, st;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s, st);
            d = {d[6:0], s};
            chk(st, "R10 data bit stable while clock high", {31'd0, st}, 32'd1);
        end
        clk_bit(1'b1, s, st);   // host not-acknowledge
    endtask

    task automatic wr_reg(input logic [7:0] abyte, input logic [7:0] idx,
                          input logic [7:0] data, input logic exp_ack, input string tag);
        logic a;
        cmp_en = 1'b0;
        h_start();
        send_byte(abyte, a);
        chk(a == ~exp_ack, {tag, " address ack"}, {31'd0, a}, {31'd0, ~exp_ack});
        send_byte(idx, a);
        chk(a == ~exp_ack, {tag, " index ack"}, {31'd0, a}, {31'd0, ~exp_ack});
        send_byte(data, a);
        chk(a == ~exp_ack, {tag, " data ack"}, {31'd0, a}, {31'd0, ~exp_ack});
        h_stop();
        if (exp_ack && !en_n) model[idx] = data & kept(int'(idx));
        wt(4);
        cmp_en = 1'b1;
    endtask

    task automatic rd_reg(input logic [7:0] idx, input string tag);
        logic a;
        logic [7:0] d;
        logic [7:0] e;
        cmp_en = 1'b0;
        h_start();
        send_byte(8'h00, a);
        chk(a == 1'b0, {tag, " read addr ack"}, {31'd0, a}, 32'd0);
        send_byte(idx, a);
        chk(a == 1'b0, {tag, " read index ack"}, {31'd0, a}, 32'd0);
        h_rstart();
        send_byte(8'h01, a);
        chk(a == 1'b0, {tag, " read-dir addr ack"}, {31'd0, a}, 32'd0);
        recv_byte(d);
        h_stop();
        e = (idx == 8'h00) ? 8'h46 : model[idx];
        chk(d == e, {tag, " read data"}, {24'd0, d}, {24'd0, e});
        wt(4);
        cmp_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        wt(5);
        // R6 reset state
        chk(sda_oe == 1'b0, "R6 reset sda released", {31'd0, sda_oe}, 32'd0);
        chk(port_fields == '0, "R6 reset fields zero", port_fields[31:0], 32'd0);
        rst_n = 1'b1;
        en_n  = 1'b0;
        wt(10);
        cmp_en = 1'b1;

        rd_reg(8'h00, "R5");
        wr_reg(8'h00, 8'h02, 8'hA5, 1'b1, "R3");
        rd_reg(8'h02, "R4");

        // R6 all-ones then patterned writes across the writable range
        for (int i = 2; i < 20; i++) wr_reg(8'h00, 8'(i), 8'hFF, 1'b1, "R6");
        for (int i = 2; i < 20; i++) rd_reg(8'(i), "R6");
        for (int i = 2; i < 20; i++) wr_reg(8'h00, 8'(i), 8'((i * 37 + 11) % 256), 1'b1, "R3");
        for (int i = 2; i < 20; i++) rd_reg(8'(i), "R9");

        // R5 id write ignored
        wr_reg(8'h00, 8'h00, 8'h12, 1'b1, "R5");
        rd_reg(8'h00, "R5");

        // R7 unmapped
        wr_reg(8'h00, 8'h01, 8'h3C, 1'b1, "R7");
        wr_reg(8'h00, 8'h14, 8'h3C, 1'b1, "R7");
        wr_reg(8'h00, 8'hFF, 8'h3C, 1'b1, "R7");
        rd_reg(8'h01, "R7");
        rd_reg(8'h14, "R7");
        rd_reg(8'hFF, "R7");

        // R2 wrong address: no ack, no write
        wr_reg(8'h20, 8'h04, 8'h77, 1'b0, "R2");
        wr_reg(8'h02, 8'h04, 8'h77, 1'b0, "R2");
        rd_reg(8'h04, "R2");

        // R8 disabled interface
        en_n = 1'b1;
        wt(8);
        wr_reg(8'h00, 8'h08, 8'hC3, 1'b0, "R8");
        en_n = 1'b0;
        wt(8);
        rd_reg(8'h08, "R8");

        // R1 repeated start redirects a write
        cmp_en = 1'b0;
        h_start();
        send_byte(8'h00, a);
        send_byte(8'h04, a);
        h_rstart();
        send_byte(8'h00, a);
        send_byte(8'h06, a);
        send_byte(8'h5A, a);
        chk(a == 1'b0, "R1 data ack after repeated start", {31'd0, a}, 32'd0);
        h_stop();
        model[6] = 8'h5A;
        wt(4);
        cmp_en = 1'b1;
        rd_reg(8'h06, "R1");
        rd_reg(8'h04, "R1");

        // R1 stop before data writes nothing
        cmp_en = 1'b0;
        h_start();
        send_byte(8'h00, a);
        send_byte(8'h09, a);
        h_stop();
        wt(4);
        cmp_en = 1'b1;
        rd_reg(8'h09, "R1");

        // R2 read-direction with wrong address is not acknowledged
        cmp_en = 1'b0;
        h_start();
        send_byte(8'h00, a);
        send_byte(8'h02, a);
        h_rstart();
        send_byte(8'h03, a);
        chk(a == 1'b1, "R2 wrong read address nack", {31'd0, a}, 32'd1);
        recv_byte(d);
        chk(d == 8'hFF, "R2 line released after nack", {24'd0, d}, 32'hFF);
        h_stop();
        wt(4);
        cmp_en = 1'b1;

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule